// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a single-channel SPI master that software drives through six 32-bit registers on a simple synchronous read/write bus. Software first programs a configuration word that holds the character length, the SCK divider, the bit order, a loopback switch and the enable and master-select bits. It then writes one character to the transmit register. The block shifts that character out on MOSI in SPI mode 0 and samples MISO at the same time. When the last bit has been sampled, the received character is placed in the receive register.

Two event flags report progress. One flag says that a received character is waiting. The other says that the shifter is free to accept a new character. Each flag is cleared by writing a one to its bit. The interrupt output is the OR of the events that the mask register lets through. Chip selects are driven outside the block.

The register bus has no back-pressure. Every access with `bus_en` high completes on the clock edge where it is presented, and read data appears on `bus_rdata` one cycle later. The flow of serial data is paced entirely by the transmitter-free event, so software must wait for that flag before it writes the next character.

Top module: `spi_master_regs`

## Requirements
- R1: Registers are decoded on byte offsets with `bus_addr[1:0]` ignored: config 0x20, events 0x24, mask 0x28, command 0x2C, transmit 0x30, receive 0x34. Every other offset reads zero and ignores writes. After reset, config, mask, command and receive read 0, events read 0x100, `irq` is 0 and `sck` is 0.
- R2: Config register bits: 30 loopback, 26 MSB-first, 25 master, 24 enable, 23:20 length code, 19:16 divider. Only these bits are stored; writing all ones reads back 0x47FF0000.
- R3: Length code 0 gives 32-bit characters, and a code n from 3 to 15 gives n+1 bits (code 3 = 4 bits). A transfer produces exactly that many SCK rising edges.
- R4: Characters are right-justified. The transmit bits above the character length are never sent, and the receive register holds the character in its low bits with zeros above.
- R5: With bit 26 set, the highest bit of the character is sent and received first. With bit 26 clear, bit 0 goes first.
- R6: With loopback set, the receiver samples the block's own MOSI and MISO is ignored.
- R7: SCK idles low, and its period is 4 x (divider + 1) system clocks. MOSI holds its value while SCK is high, and the receiver samples on SCK rising edges.
- R8: When a character completes, the receive register is loaded and event bit 9 (receiver-not-empty) is set. Reading the receive register does not clear bit 9.
- R9: Event bit 8 (transmitter-free) is cleared when a transfer starts and set when the transfer completes.
- R10: Writing a one to an event bit clears that bit. Writing a zero leaves the bit unchanged.
- R11: `irq` is high exactly when some event bit is set and its mask bit is also set. A zero mask keeps `irq` low.
- R12: A transmit write starts a transfer only when enable and master are both set and no transfer is running. Any other transmit write has no effect.
- R13: The command register is stored and read back, and its value has no effect on transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Masked event interrupt |

## Verification
The hardest case to reach from the ports is a character whose length and bit order must both be correct at the same time. A right-justified, LSB-first, 13-bit word exercises a different index path than a 32-bit MSB-first word. For that reason the bench sweeps every length code against both bit orders and against both loopback and an external responder. The responder is a small slave model that shifts a separate pattern on falling SCK edges and captures MOSI on rising ones. Two further cases need deliberate timing: a second transmit write that arrives while a shift is running, and an event read taken in the middle of a shift. The bench produces both by issuing the access a fixed number of cycles after the start, well inside the shortest transfer that the chosen divider allows.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

  localparam logic [7:0] OFF_CFG  = 8'h20;
  localparam logic [7:0] OFF_EVT  = 8'h24;
  localparam logic [7:0] OFF_MSK  = 8'h28;
  localparam logic [7:0] OFF_CMD  = 8'h2C;
  localparam logic [7:0] OFF_TXD  = 8'h30;
  localparam logic [7:0] OFF_RXD  = 8'h34;

  localparam int CB_LOOP = 30;
  localparam int CB_MSBF = 26;
  localparam int CB_MSTR = 25;
  localparam int CB_ENA  = 24;
  localparam int CB_LEN  = 20;
  localparam int CB_DIV  = 16;
  localparam logic [31:0] CFG_KEEP = 32'h47FF_0000;

  localparam int EB_RNE = 9;
  localparam int EB_TNF = 8;

  // number of bits in a character for a length code
  function automatic int char_bits(input logic [3:0] code);
    if (code == 4'd0)      return 32;
    else if (code < 4'd4)  return 4;
    else                   return int'(code) + 1;
  endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int DIV_W = 4,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             rise,
  output logic             fall
);
  // half period = 2*(div+1) system clocks, so reload value is 2*div+1
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;
  logic             tick;

  assign reload = {div, 1'b1};
  assign tick   = run && !start && (cnt_q == '0);
  assign rise   = tick && !sck;
  assign fall   = tick && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else if (start) begin
      cnt_q <= reload;
      sck   <= 1'b0;
    end else if (run) begin
      if (cnt_q == '0) begin
        cnt_q <= reload;
        sck   <= ~sck;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      sck <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DW = 32,
  localparam int IW = $clog2(DW) + 1,
  localparam int XW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] tx_word,
  input  logic [3:0]    len_code,
  input  logic          msb_first,
  input  logic          loop_en,
  input  logic          miso,
  input  logic          rise,
  input  logic          fall,
  output logic          busy,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx_word
);
  import spi_master_pkg::*;

  logic [DW-1:0] tx_q;
  logic [DW-1:0] rx_q;
  logic [IW-1:0] nbits_q;
  logic [IW-1:0] bitcnt_q;
  logic          msbf_q;
  logic          loop_q;
  logic [IW-1:0] pos;
  logic [XW-1:0] ix;
  logic          last;
  logic          rx_bit;

  assign pos    = msbf_q ? (nbits_q - 1'b1 - bitcnt_q) : bitcnt_q;
  assign ix     = pos[XW-1:0];
  assign last   = (bitcnt_q == nbits_q - 1'b1);
  assign mosi   = busy && tx_q[ix];
  assign rx_bit = loop_q ? mosi : miso;
  assign done   = busy && fall && last;
  assign rx_word = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      tx_q     <= '0;
      rx_q     <= '0;
      nbits_q  <= IW'(4);
      bitcnt_q <= '0;
      msbf_q   <= 1'b0;
      loop_q   <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      tx_q     <= tx_word;
      rx_q     <= '0;
      nbits_q  <= IW'(char_bits(len_code));
      bitcnt_q <= '0;
      msbf_q   <= msb_first;
      loop_q   <= loop_en;
    end else if (busy) begin
      if (rise) rx_q[ix] <= rx_bit;
      if (fall) begin
        if (last) busy <= 1'b0;
        else      bitcnt_q <= bitcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs #(
  parameter int DIV_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        irq
);
  import spi_master_pkg::*;

  logic [31:0] cfg_q, msk_q, cmd_q, rxd_q;
  logic        ev_rne, ev_tnf;
  logic [7:0]  off;
  logic        wr, rd;
  logic        start, busy, done, rise, fall;
  logic [31:0] rx_word, evt_word;

  assign off = {bus_addr[7:2], 2'b00};
  assign wr  = bus_en && bus_we;
  assign rd  = bus_en && !bus_we;

  assign start = wr && (off == OFF_TXD) && cfg_q[CB_ENA] && cfg_q[CB_MSTR] && !busy;

  assign evt_word = {22'd0, ev_rne, ev_tnf, 8'd0};
  assign irq      = |(evt_word & msk_q);

  spi_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .run  (busy),
    .div  (cfg_q[CB_DIV +: DIV_W]),
    .sck  (sck),
    .rise (rise),
    .fall (fall)
  );

  spi_shift_engine #(.DW(32)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tx_word  (bus_wdata),
    .len_code (cfg_q[CB_LEN +: 4]),
    .msb_first(cfg_q[CB_MSBF]),
    .loop_en  (cfg_q[CB_LOOP]),
    .miso     (miso),
    .rise     (rise),
    .fall     (fall),
    .busy     (busy),
    .mosi     (mosi),
    .done     (done),
    .rx_word  (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      msk_q  <= '0;
      cmd_q  <= '0;
      rxd_q  <= '0;
      ev_rne <= 1'b0;
      ev_tnf <= 1'b1;
    end else begin
      if (wr && off == OFF_CFG) cfg_q <= bus_wdata & CFG_KEEP;
      if (wr && off == OFF_MSK) msk_q <= bus_wdata;
      if (wr && off == OFF_CMD) cmd_q <= bus_wdata;
      if (wr && off == OFF_EVT) begin
        if (bus_wdata[EB_RNE]) ev_rne <= 1'b0;
        if (bus_wdata[EB_TNF]) ev_tnf <= 1'b0;
      end
      if (start) ev_tnf <= 1'b0;
      if (done) begin
        ev_rne <= 1'b1;
        ev_tnf <= 1'b1;
        rxd_q  <= rx_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd) begin
      case (off)
        OFF_CFG: bus_rdata <= cfg_q;
        OFF_EVT: bus_rdata <= evt_word;
        OFF_MSK: bus_rdata <= msk_q;
        OFF_CMD: bus_rdata <= cmd_q;
        OFF_RXD: bus_rdata <= rxd_q;
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_master_regs_chk.sv
module spi_master_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sck,
  input logic        mosi,
  input logic        irq,
  input logic        busy,
  input logic        ev_rne,
  input logic        ev_tnf,
  input logic [31:0] msk_q
);
  // R11: an all-zero mask never lets the interrupt through
  a_r11_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == 32'd0) |-> !irq);

  // R9: the transmitter-free flag stays low while a character is shifting
  a_r9_tnf_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_tnf);

  // R8: receiver-not-empty only rises at the end of a transfer
  a_r8_rne_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_rne) |-> $fell(busy));

  // R7: SCK only rises inside a transfer
  a_r7_sck_rise_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> busy);

  // R7: SCK is low whenever no transfer runs
  a_r7_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !sck);

  // R7: MOSI holds across the high phase of SCK
  a_r7_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
endmodule

bind spi_master_regs spi_master_regs_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .sck   (sck),
  .mosi  (mosi),
  .irq   (irq),
  .busy  (busy),
  .ev_rne(ev_rne),
  .ev_tnf(ev_tnf),
  .msk_q (msk_q)
);

// File: tb/spi_master_regs_test.sv
`timescale 1ns/1ps
module spi_master_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        sck, mosi, irq;
  logic        miso = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  spi_master_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
  );

  // slave responder model
  int          s_len = 32;
  bit          s_msbf = 1'b0;
  logic [31:0] s_pat = '0;
  logic [31:0] s_cap = '0;
  int          s_idx = 0;
  int          rise_cnt = 0;
  int          last_rise = 0;
  int          period = 0;

  function automatic int spos(int i);
    return s_msbf ? (s_len - 1 - i) : i;
  endfunction

  always @(posedge sck) begin
    if (s_idx < s_len) s_cap[spos(s_idx)] = mosi;
    rise_cnt++;
    period = cyc - last_rise;
    last_rise = cyc;
  end

  always @(negedge sck) begin
    s_idx++;
    if (s_idx < s_len) miso = s_pat[spos(s_idx)];
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] cfgw(int len, bit msbf, bit loop, int dv, bit en, bit ms);
    return (32'(loop) << 30) | (32'(msbf) << 26) | (32'(ms) << 25) | (32'(en) << 24)
         | (32'(len) << 20) | (32'(dv) << 16);
  endfunction

  function automatic logic [31:0] lowmask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  task automatic wait_rne(string req);
    logic [31:0] e;
    bit got = 0;
    for (int k = 0; k < 3000 && !got; k++) begin
      rd(8'h24, e);
      if (e[9]) got = 1;
    end
    if (!got) check(req, 32'h0, 32'h200);
  endtask

  task automatic arm_slave(int L, bit msbf, logic [31:0] pat);
    s_len = L; s_msbf = msbf; s_pat = pat; s_idx = 0; s_cap = '0;
    miso = pat[spos(0)];
    rise_cnt = 0;
  endtask

  task automatic xfer(int len, bit msbf, bit loop, int dv, logic [31:0] tx, logic [31:0] pat);
    logic [31:0] r;
    int L = (len == 0) ? 32 : len + 1;
    wr(8'h20, cfgw(len, msbf, loop, dv, 1, 1));
    wr(8'h24, 32'hFFFF_FFFF);
    arm_slave(L, msbf, pat);
    wr(8'h30, tx);
    wait_rne("R8 completion");
    rd(8'h34, r);
    check(loop ? "R4 R5 R6 rx loopback" : "R4 R5 rx external",
          r, (loop ? tx : pat) & lowmask(L));
    check("R3 rising edge count", 32'(rise_cnt), 32'(L));
    check("R5 slave captured", s_cap, tx & lowmask(L));
    rd(8'h24, r);
    check("R8 R9 events after done", r, 32'h300);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and decode
    rd(8'h20, r); check("R1 cfg reset", r, 32'h0);
    rd(8'h24, r); check("R1 events reset", r, 32'h100);
    rd(8'h28, r); check("R1 mask reset", r, 32'h0);
    rd(8'h2C, r); check("R1 cmd reset", r, 32'h0);
    rd(8'h34, r); check("R1 rx reset", r, 32'h0);
    check("R1 irq reset", 32'(irq), 32'h0);
    check("R1 sck idle", 32'(sck), 32'h0);
    wr(8'h04, 32'hDEAD_BEEF);
    rd(8'h04, r); check("R1 reserved reads zero", r, 32'h0);
    wr(8'h2B, 32'h0000_0300);
    rd(8'h28, r); check("R1 low address bits ignored", r, 32'h300);
    wr(8'h28, 32'h0);

    // R2 stored bits only
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, r); check("R2 cfg readback", r, 32'h47FF_0000);
    wr(8'h20, 32'h0);

    // R12 transmit write ignored when not enabled or not master
    arm_slave(8, 1, 32'h0);
    wr(8'h20, cfgw(7, 1, 0, 0, 0, 1));
    wr(8'h30, 32'h0000_00FF);
    repeat (100) @(negedge clk);
    check("R12 disabled no sck", 32'(rise_cnt), 32'h0);
    rd(8'h24, r); check("R12 disabled events unchanged", r, 32'h100);
    wr(8'h20, cfgw(7, 1, 0, 0, 1, 0));
    wr(8'h30, 32'h0000_00FF);
    repeat (100) @(negedge clk);
    check("R12 not master no sck", 32'(rise_cnt), 32'h0);

    // sweep of lengths, orders and loopback at the fastest divider
    for (int lc = 0; lc < 16; lc++) begin
      if (lc == 1 || lc == 2) continue;
      for (int o = 0; o < 2; o++) begin
        for (int lp = 0; lp < 2; lp++) begin
          xfer(lc, o[0], lp[0], 0,
               32'hA5C3_96E1 ^ (32'(lc) * 32'h0123_4567) ^ (32'(o) << 7),
               32'h3C5A_0FF1 ^ (32'(lc) * 32'h0765_4321) ^ (32'(lp) << 3));
        end
      end
    end

    // R7 divider sweep
    for (int dv = 0; dv < 16; dv++) begin
      xfer(7, 1, 0, dv, 32'h0000_0096 + 32'(dv), 32'h0000_0069 ^ 32'(dv));
      check("R7 sck period", 32'(period), 32'(4 * (dv + 1)));
      check("R7 sck idle after", 32'(sck), 32'h0);
    end

    // R9 mid-shift flag and R12 write while busy
    wr(8'h20, cfgw(7, 1, 1, 3, 1, 1));
    wr(8'h24, 32'hFFFF_FFFF);
    arm_slave(8, 1, 32'h0);
    wr(8'h30, 32'h0000_005A);
    repeat (10) @(negedge clk);
    rd(8'h24, r); check("R9 tnf low during shift", r, 32'h0);
    wr(8'h30, 32'h0000_00FF);
    wait_rne("R12 busy completion");
    rd(8'h34, r); check("R12 busy write ignored", r, 32'h5A);

    // R8 receive read does not clear
    rd(8'h34, r);
    rd(8'h24, r); check("R8 rx read keeps rne", r, 32'h300);

    // R11 and R10
    check("R11 zero mask irq low", 32'(irq), 32'h0);
    wr(8'h28, 32'h0000_0200);
    check("R11 rne unmasked irq", 32'(irq), 32'h1);
    wr(8'h24, 32'h0000_0200);
    rd(8'h24, r); check("R10 clear rne only", r, 32'h100);
    check("R11 irq after clear", 32'(irq), 32'h0);
    wr(8'h28, 32'h0000_0100);
    check("R11 tnf unmasked irq", 32'(irq), 32'h1);
    wr(8'h24, 32'h0000_0000);
    rd(8'h24, r); check("R10 zero write keeps", r, 32'h100);
    wr(8'h24, 32'h0000_0100);
    rd(8'h24, r); check("R10 clear tnf", r, 32'h0);
    check("R11 irq none", 32'(irq), 32'h0);
    wr(8'h28, 32'h0);

    // R13 command register has no effect
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, r); check("R13 cmd readback", r, 32'hFFFF_FFFF);
    xfer(11, 0, 0, 1, 32'h0000_0ABC, 32'h0000_0543);
    xfer(0, 1, 1, 0, 32'h8001_7FFE, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule